// File: doc/BRIEF.md
# OTG Pin Status and Change Interrupt Register

This block is a single 32-bit control and status word for an OTG port. It watches two board-level signals: the ID pin and the B-session-valid indication. Both enter through a two-flop synchroniser. Software can read their present levels from the word.

Every change of either signal, rising or falling, sets a sticky status bit for that source. The status bit sets whether or not the source is enabled. Each source also has an enable bit. The single interrupt request is high while any source has both its status bit and its enable bit set.

Software acknowledges a source by writing a one to its status bit. Writing back the word it has just read therefore clears whatever was pending and keeps the enables it read. Writing an all-zero word at start-up masks every source.

Top module: `otg_sc_reg`

## Requirements
- R1: While reset is asserted, the read word is all zeros and the interrupt request is low.
- R2: Bit 8 of the read word shows the ID level (1 = B-device or no A-plug), two clocks after the pin changes.
- R3: Bit 11 of the read word shows the B-session-valid level, two clocks after the input changes.
- R4: Bit 16 latches to 1 on any rising or falling change of the synchronised ID level, whatever the enable bits hold.
- R5: Bit 19 latches to 1 on any rising or falling change of the synchronised session-valid level, whatever the enable bits hold.
- R6: Every write loads bit 24 (ID-change enable) and bit 27 (session-change enable) from the write data, and both read back.
- R7: The interrupt request is high exactly when (bit 16 and bit 24) or (bit 19 and bit 27) is set.
- R8: A write clears status bit 16 or 19 where the write data has a 1 in that position. A 0 in that position leaves the status bit unchanged.
- R9: When a change of a source and a clearing write to its status bit happen in the same cycle, the status bit ends set.
- R10: A write of an all-zero word masks both sources and drops the interrupt request. Pending status bits are kept.
- R11: The input levels present when reset is released produce no status bit.
- R12: All read bits other than 8, 11, 16, 19, 24 and 27 read as zero, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_i | input | 1 | ID pin level, asynchronous |
| bsv_i | input | 1 | B-session-valid level, asynchronous |
| wr_i | input | 1 | Write strobe for the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
A change detected on a source and a software write that clears the same status bit can land in one clock cycle. The bench sets the ID status bit first. It then toggles the ID pin. The clearing write is timed to the cycle in which the synchronised change reaches the edge detector, counting one edge for each synchroniser flop and one for the history flop. The status bit must read back as set after that write. A later plain clear must take it to zero, which shows that the change was counted only once.

// File: rtl/otg_sc_pkg.sv
package otg_sc_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 2;
  localparam int STS_OFS = 8;   // status sits this far above its level bit
  localparam int EN_OFS  = 16;  // enable sits this far above its level bit

  // level bit of source i: 0 = ID, 1 = B-session-valid
  function automatic int lvl_pos(input int i);
    return (i == 0) ? 8 : 11;
  endfunction
endpackage

// File: rtl/otg_sc_sync.sv
module otg_sc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic chg_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic [STAGES:0]   rdy_q;  // blocks change detection until the chain holds real samples

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
      rdy_q  <= '0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      prev_q <= sh_q[STAGES-1];
      rdy_q  <= {rdy_q[STAGES-1:0], 1'b1};
    end
  end

  assign lvl_o = sh_q[STAGES-1];
  assign chg_o = rdy_q[STAGES] & (sh_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/otg_sc_stat.sv
module otg_sc_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic st_o
);
  logic st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= (st_q & ~clr_i) | set_i;  // set beats clear
  end

  assign st_o = st_q;

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> st_o);
  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !st_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(st_o));
endmodule

// File: rtl/otg_sc_reg.sv
module otg_sc_reg
  import otg_sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_i,
  input  logic              bsv_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] src_in;
  logic [NUM_SRC-1:0] lvl, chg, st, en_q, clr;

  assign src_in = {bsv_i, id_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int LP = lvl_pos(g);

    otg_sc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (src_in[g]),
      .lvl_o (lvl[g]),
      .chg_o (chg[g])
    );

    assign clr[g] = wr_i & wdata_i[LP+STS_OFS];

    otg_sc_stat u_stat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (chg[g]),
      .clr_i (clr[g]),
      .st_o  (st[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[g] <= 1'b0;
      else if (wr_i) en_q[g] <= wdata_i[LP+EN_OFS];
    end

    p_en_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (en_q[g] == $past(wdata_i[LP+EN_OFS])));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      rdata_o[lvl_pos(i)]         = lvl[i];
      rdata_o[lvl_pos(i)+STS_OFS] = st[i];
      rdata_o[lvl_pos(i)+EN_OFS]  = en_q[i];
    end
  end

  assign irq_o = |(st & en_q);

  p_irq_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|en_q && |st));
  p_zero_masks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: tb/sim_otg_sc_reg.sv
module sim_otg_sc_reg;
  localparam int CLK_P = 10;
  localparam logic [31:0] DEF_MASK = 32'h0909_0900;

  logic clk = 1'b0, rst_n = 1'b0, id = 1'b1, bsv = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  otg_sc_reg u0 (.clk_i(clk), .rst_ni(rst_n), .id_i(id), .bsv_i(bsv),
                 .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [31:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 word", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 no status from start levels", rdata, 32'h0000_0100);
  endtask

  task automatic t_bsv();
    bsv = 1'b1; settle();
    chk("R3/R5 bsv rise", rdata, 32'h0008_0900);
    wreg(32'h0009_0000);
    chk("R8 w1c both", rdata, 32'h0000_0900);
    bsv = 1'b0; settle();
    chk("R5 bsv fall", rdata, 32'h0008_0100);
    wreg(32'h0008_0000);
  endtask

  task automatic t_id();
    id = 1'b0;
    @(negedge clk);
    chk("R2 level not yet", rdata & 32'h100, 32'h100);
    @(negedge clk);
    chk("R2 level after two clocks", rdata & 32'h100, 32'h0);
    settle();
    chk("R4 id fall", rdata, 32'h0001_0000);
    chk("R7 masked irq", {31'b0, irq}, 32'h0);
    wreg(32'h0001_0000);
    id = 1'b1; settle();
    chk("R4 id rise", rdata, 32'h0001_0100);
    wreg(32'h0001_0000);
    chk("R8 cleared", rdata, 32'h0000_0100);
  endtask

  task automatic t_en_irq();
    wreg(32'h0900_0000);
    chk("R6 enables read back", rdata, 32'h0900_0100);
    chk("R7 no status no irq", {31'b0, irq}, 32'h0);
    id = 1'b0; settle();
    chk("R7 irq on enabled id", {31'b0, irq}, 32'h1);
    wreg(32'h0800_0000);
    chk("R8 zero leaves status", rdata, 32'h0801_0000);
    chk("R7 irq drops when id masked", {31'b0, irq}, 32'h0);
    bsv = 1'b1; settle();
    chk("R7 irq on enabled bsv", {31'b0, irq}, 32'h1);
    wreg(32'h0909_0000);
    chk("R7 irq after clear", {31'b0, irq}, 32'h0);
    chk("R6/R8 word", rdata, 32'h0900_0800);
  endtask

  task automatic t_zero();
    id = 1'b1; settle();
    chk("R10 irq before", {31'b0, irq}, 32'h1);
    wreg(32'h0);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    chk("R10 status kept", rdata, 32'h0001_0900);
    wreg(32'h0001_0000);
  endtask

  task automatic t_collide();
    id = 1'b0; settle();
    chk("R9 pre set", rdata & 32'h0001_0000, 32'h0001_0000);
    @(negedge clk); id = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; wdata = 32'h0001_0000;
    @(negedge clk); wr = 1'b0; wdata = '0;
    chk("R9 change beats clear", rdata & 32'h0001_0000, 32'h0001_0000);
    settle();
    wreg(32'h0001_0000);
    chk("R9 single clear after", rdata, 32'h0000_0900);
  endtask

  task automatic t_unused();
    wreg(32'hFFFF_FFFF);
    chk("R12 reserved zero", rdata & ~DEF_MASK, 32'h0);
    chk("R12 word", rdata, 32'h0900_0900);
  endtask

  initial begin
    t_reset();
    t_bsv();
    t_id();
    t_en_irq();
    t_zero();
    t_collide();
    t_unused();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule